// File: doc/BRIEF.md
# Host Direct Graphics RAM Port

This block lets a host processor read and write the frame and depth storage of two graphics RAM banks directly, without going through a rendering pipeline. Each bank holds 2048 rows of 512 columns, and every location is 64 bits wide. A location is split into four 16-bit lanes that hold two 15-bit RGB pixels and their two depth values. Depth is usually cleared to 0x7FFF.

The host sees four 32-bit registers: two data registers, an address register and a control register. Each data register carries one pixel and its depth. The control register chooses which banks take a write, which of the four lanes are written, whether the address steps after each transfer, and whether writing the address starts a read. Writing the second data register commits the location. A read places the fetched location back into both data registers, where the host can collect it.

Top module: `gram_host_port`

## Requirements
- R1: After reset the data, address and control registers read back as zero, and no RAM write or read strobe is active.
- R2: The address register holds the column in bits 8:0 and the row in bits 22:12. All other bits read back as zero. Host register select values are: 0 for data A, 1 for data B, 2 for address, 3 for control.
- R3: Writing data A only stages the value. It causes no RAM strobe and leaves the RAM unchanged.
- R4: While control bit 0 is set, writing data B raises a write strobe in the following cycle. mem_we_o[0] is raised for bank 0 when control bit 31 is set, and mem_we_o[1] for bank 1 when control bit 30 is set. The strobe lasts one cycle and carries the current address as {row, col} on mem_addr_o.
- R5: The committed 64-bit word places its 16-bit lanes from the low end upward in the order pixel 0 = A[15:0], pixel 1 = B[15:0], depth 0 = A[31:16], depth 1 = B[31:16]. Lane mask bits 0 to 3 come from control bits 20 to 23, and only masked lanes change in RAM.
- R6: With control bit 17 set, each commit steps the address. The column increases first. When the column passes 511 it returns to 0 and the row increases, and row 2047 wraps to row 0. With bit 17 clear the address stays where it is.
- R7: While control bits 0 and 16 are set, writing the address loads it and, in the next cycle, raises a one-cycle read strobe at the new address. Both data registers hold the fetched location, unpacked with the lane order of R5, from the third cycle after the address write.
- R8: A read takes bank 1 only when control bit 30 is set and bit 31 is clear. Otherwise it takes bank 0. At most one read strobe is active at a time.
- R9: While control bit 0 is clear, data and address writes raise no RAM strobe and do not step the address. Data registers still stage host writes.
- R10: A read started with control bit 17 set steps the address once, after the loaded address has been used for the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| host_we_i | input | 1 | Host register write strobe |
| host_sel_i | input | 2 | Host register select (0 data A, 1 data B, 2 address, 3 control) |
| host_wdata_i | input | 32 | Host write data |
| host_rdata_o | output | 32 | Read-back of the selected register |
| mem_we_o | output | 2 | Per-bank RAM write strobe |
| mem_re_o | output | 2 | Per-bank RAM read strobe |
| mem_addr_o | output | 20 | RAM location as {row, col} |
| mem_wdata_o | output | 64 | RAM write word |
| mem_wmask_o | output | 4 | Per-lane write mask |
| mem_rdata0_i | input | 64 | Bank 0 read data, one cycle after the strobe |
| mem_rdata1_i | input | 64 | Bank 1 read data, one cycle after the strobe |

## Verification
A corrupted address counter shows up at the next strobe as a wrong mem_addr_o. It also shows up at once when the host reads the address register, and the carry from column 511 into the next row is the case most likely to expose it. A wrong lane permutation or mask appears on mem_wdata_o and mem_wmask_o in the same cycle as the strobe. When such a word is read back, it reaches the data registers three cycles after the address write. A bad read-bank choice or a stuck capture path corrupts both data registers on that same third cycle.

// File: rtl/gram_pkg.sv
package gram_pkg;
  localparam int COL_W   = 9;
  localparam int ROW_W   = 11;
  localparam int FIELD_W = 12;
  localparam int LANE_W  = 16;
  localparam int LANES   = 4;
  localparam int WORD_W  = 2 * LANE_W;
  localparam int LOC_W   = LANES * LANE_W;
  localparam int ADDR_W  = COL_W + ROW_W;
  localparam int NBANK   = 2;

  // control bit positions
  localparam int CTL_EN    = 0;
  localparam int CTL_RD    = 16;
  localparam int CTL_INC   = 17;
  localparam int CTL_LANE0 = 20;
  localparam int CTL_BANK1 = 30;
  localparam int CTL_BANK0 = 31;

  typedef enum logic [1:0] {
    SEL_DATA_A = 2'd0,
    SEL_DATA_B = 2'd1,
    SEL_ADDR   = 2'd2,
    SEL_CTRL   = 2'd3
  } host_sel_e;
endpackage

// File: rtl/gram_addr_gen.sv
module gram_addr_gen #(
  parameter int COL_W = 9,
  parameter int ROW_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [COL_W-1:0] load_col_i,
  input  logic [ROW_W-1:0] load_row_i,
  input  logic             step_i,
  output logic [COL_W-1:0] col_o,
  output logic [ROW_W-1:0] row_o
);
  localparam logic [COL_W-1:0] COL_LAST = '1;

  logic [COL_W-1:0] col_q, base_col, nxt_col;
  logic [ROW_W-1:0] row_q, base_row, nxt_row;

  // a load and a step may coincide: the step applies to the loaded value
  always_comb begin
    base_col = load_i ? load_col_i : col_q;
    base_row = load_i ? load_row_i : row_q;
    nxt_col  = base_col;
    nxt_row  = base_row;
    if (step_i) begin
      if (base_col == COL_LAST) begin
        nxt_col = '0;
        nxt_row = base_row + ROW_W'(1);
      end else begin
        nxt_col = base_col + COL_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_q <= '0;
      row_q <= '0;
    end else begin
      col_q <= nxt_col;
      row_q <= nxt_row;
    end
  end

  assign col_o = col_q;
  assign row_o = row_q;
endmodule

// File: rtl/gram_lane_map.sv
module gram_lane_map #(
  parameter int LANE_W = 16
) (
  input  logic [2*LANE_W-1:0] word_a_i,
  input  logic [2*LANE_W-1:0] word_b_i,
  output logic [4*LANE_W-1:0] loc_o,
  input  logic [4*LANE_W-1:0] loc_i,
  output logic [2*LANE_W-1:0] word_a_o,
  output logic [2*LANE_W-1:0] word_b_o
);
  localparam int LANES = 4;

  // lane l comes from word A (even l) or B (odd l); l/2 picks pixel or depth half
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam int HALF = l / 2;
    if (l % 2 == 0) begin : g_a
      assign loc_o[l*LANE_W +: LANE_W]       = word_a_i[HALF*LANE_W +: LANE_W];
      assign word_a_o[HALF*LANE_W +: LANE_W] = loc_i[l*LANE_W +: LANE_W];
    end else begin : g_b
      assign loc_o[l*LANE_W +: LANE_W]       = word_b_i[HALF*LANE_W +: LANE_W];
      assign word_b_o[HALF*LANE_W +: LANE_W] = loc_i[l*LANE_W +: LANE_W];
    end
  end
endmodule

// File: rtl/gram_host_port.sv
module gram_host_port
  import gram_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_we_i,
  input  logic [1:0]        host_sel_i,
  input  logic [WORD_W-1:0] host_wdata_i,
  output logic [WORD_W-1:0] host_rdata_o,
  output logic [NBANK-1:0]  mem_we_o,
  output logic [NBANK-1:0]  mem_re_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [LOC_W-1:0]  mem_wdata_o,
  output logic [LANES-1:0]  mem_wmask_o,
  input  logic [LOC_W-1:0]  mem_rdata0_i,
  input  logic [LOC_W-1:0]  mem_rdata1_i
);
  localparam int PAD_HI = WORD_W - FIELD_W - ROW_W;
  localparam int PAD_LO = FIELD_W - COL_W;

  logic [WORD_W-1:0] data_a_q, data_b_q, ctrl_q;
  logic [COL_W-1:0]  col;
  logic [ROW_W-1:0]  row;
  logic [NBANK-1:0]  mem_we_q, mem_re_q, rd_pend_q;
  logic [ADDR_W-1:0] mem_addr_q;
  logic [LOC_W-1:0]  mem_wdata_q, pack_loc, rd_loc;
  logic [LANES-1:0]  mem_wmask_q;
  logic [WORD_W-1:0] rd_a, rd_b;

  host_sel_e sel;
  logic wr_a, wr_b, wr_addr, wr_ctrl, enabled, commit, rd_go, step, rd_bank1, capture;
  logic [COL_W-1:0] ld_col;
  logic [ROW_W-1:0] ld_row;

  assign sel      = host_sel_e'(host_sel_i);
  assign wr_a     = host_we_i && sel == SEL_DATA_A;
  assign wr_b     = host_we_i && sel == SEL_DATA_B;
  assign wr_addr  = host_we_i && sel == SEL_ADDR;
  assign wr_ctrl  = host_we_i && sel == SEL_CTRL;
  assign enabled  = ctrl_q[CTL_EN];
  assign commit   = wr_b && enabled;
  assign rd_go    = wr_addr && enabled && ctrl_q[CTL_RD];
  assign step     = (commit || rd_go) && ctrl_q[CTL_INC];
  assign rd_bank1 = ctrl_q[CTL_BANK1] && !ctrl_q[CTL_BANK0];
  assign capture  = |rd_pend_q;
  assign ld_col   = host_wdata_i[COL_W-1:0];
  assign ld_row   = host_wdata_i[FIELD_W +: ROW_W];

  gram_addr_gen #(.COL_W(COL_W), .ROW_W(ROW_W)) addr_gen_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (wr_addr),
    .load_col_i (ld_col),
    .load_row_i (ld_row),
    .step_i     (step),
    .col_o      (col),
    .row_o      (row)
  );

  assign rd_loc = rd_pend_q[1] ? mem_rdata1_i : mem_rdata0_i;

  gram_lane_map #(.LANE_W(LANE_W)) lane_map_i (
    .word_a_i (data_a_q),
    .word_b_i (host_wdata_i),
    .loc_o    (pack_loc),
    .loc_i    (rd_loc),
    .word_a_o (rd_a),
    .word_b_o (rd_b)
  );

  // host registers; returning read data wins over a host write in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_a_q <= '0;
      data_b_q <= '0;
      ctrl_q   <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= host_wdata_i;
      if (capture) begin
        data_a_q <= rd_a;
        data_b_q <= rd_b;
      end else begin
        if (wr_a) data_a_q <= host_wdata_i;
        if (wr_b) data_b_q <= host_wdata_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_we_q    <= '0;
      mem_re_q    <= '0;
      rd_pend_q   <= '0;
      mem_addr_q  <= '0;
      mem_wdata_q <= '0;
      mem_wmask_q <= '0;
    end else begin
      mem_we_q  <= commit ? {ctrl_q[CTL_BANK1], ctrl_q[CTL_BANK0]} : '0;
      mem_re_q  <= rd_go ? (rd_bank1 ? 2'b10 : 2'b01) : '0;
      rd_pend_q <= mem_re_q;
      if (commit) begin
        mem_addr_q  <= {row, col};
        mem_wdata_q <= pack_loc;
        mem_wmask_q <= ctrl_q[CTL_LANE0 +: LANES];
      end else if (rd_go) begin
        mem_addr_q  <= {ld_row, ld_col};
      end
    end
  end

  always_comb begin
    unique case (sel)
      SEL_DATA_A: host_rdata_o = data_a_q;
      SEL_DATA_B: host_rdata_o = data_b_q;
      SEL_ADDR:   host_rdata_o = {{PAD_HI{1'b0}}, row, {PAD_LO{1'b0}}, col};
      default:    host_rdata_o = ctrl_q;
    endcase
  end

  assign mem_we_o    = mem_we_q;
  assign mem_re_o    = mem_re_q;
  assign mem_addr_o  = mem_addr_q;
  assign mem_wdata_o = mem_wdata_q;
  assign mem_wmask_o = mem_wmask_q;
endmodule

// File: rtl/gram_host_port_chk.sv
module gram_host_port_chk
  import gram_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              host_we_i,
  input logic [1:0]        host_sel_i,
  input logic [WORD_W-1:0] host_rdata_o,
  input logic [NBANK-1:0]  mem_we_o,
  input logic [NBANK-1:0]  mem_re_o,
  input logic [LANES-1:0]  mem_wmask_o,
  input logic [WORD_W-1:0] ctrl_q
);
  assert_addr_pad_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_sel_i == 2'd2 |-> (host_rdata_o[WORD_W-1:FIELD_W+ROW_W] == '0 &&
                            host_rdata_o[FIELD_W-1:COL_W] == '0));

  assert_we_source_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |mem_we_o |-> $past(host_we_i && host_sel_i == 2'd1));

  assert_no_rw_overlap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|mem_we_o && |mem_re_o));

  assert_mask_src_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |mem_we_o |-> mem_wmask_o == $past(ctrl_q[CTL_LANE0 +: LANES]));

  assert_re_source_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |mem_re_o |-> $past(host_we_i && host_sel_i == 2'd2 && ctrl_q[CTL_RD]));

  assert_re_onehot_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(mem_re_o));

  assert_re_bank_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_re_o[1] |-> $past(ctrl_q[CTL_BANK1] && !ctrl_q[CTL_BANK0]));

  assert_quiet_when_off_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|mem_we_o || |mem_re_o) |-> $past(ctrl_q[CTL_EN]));
endmodule

bind gram_host_port gram_host_port_chk chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .host_we_i    (host_we_i),
  .host_sel_i   (host_sel_i),
  .host_rdata_o (host_rdata_o),
  .mem_we_o     (mem_we_o),
  .mem_re_o     (mem_re_o),
  .mem_wmask_o  (mem_wmask_o),
  .ctrl_q       (ctrl_q)
);

// File: tb/gram_host_port_tb_top.sv
module gram_host_port_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        host_we = 1'b0;
  logic [1:0]  host_sel = 2'd0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic [1:0]  mem_we, mem_re;
  logic [19:0] mem_addr;
  logic [63:0] mem_wdata, rd0, rd1;
  logic [3:0]  mem_wmask;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  gram_host_port dut_i (
    .clk_i(clk), .rst_ni(rst_n), .host_we_i(host_we), .host_sel_i(host_sel),
    .host_wdata_i(host_wdata), .host_rdata_o(host_rdata), .mem_we_o(mem_we),
    .mem_re_o(mem_re), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_wmask_o(mem_wmask), .mem_rdata0_i(rd0), .mem_rdata1_i(rd1)
  );

  function automatic logic [63:0] seed(int b, int a);
    return {32'(a) ^ (b != 0 ? 32'hFFFF0000 : 32'h0), 32'hC0DE0000 | 32'(a & 16'hFFFF)};
  endfunction

  function automatic logic [63:0] merge(logic [63:0] old, logic [63:0] nw, logic [3:0] m);
    logic [63:0] r = old;
    for (int l = 0; l < 4; l++) if (m[l]) r[l*16 +: 16] = nw[l*16 +: 16];
    return r;
  endfunction

  function automatic logic [31:0] half_a(logic [63:0] loc);
    return {loc[47:32], loc[15:0]};
  endfunction
  function automatic logic [31:0] half_b(logic [63:0] loc);
    return {loc[63:48], loc[31:16]};
  endfunction

  // RAM model: one-cycle registered read
  logic [63:0] ram0 [int];
  logic [63:0] ram1 [int];
  always @(posedge clk) begin
    int k;
    k = int'(mem_addr);
    if (mem_we[0]) ram0[k] = merge(ram0.exists(k) ? ram0[k] : seed(0, k), mem_wdata, mem_wmask);
    if (mem_we[1]) ram1[k] = merge(ram1.exists(k) ? ram1[k] : seed(1, k), mem_wdata, mem_wmask);
    if (mem_re[0]) rd0 <= ram0.exists(k) ? ram0[k] : seed(0, k);
    if (mem_re[1]) rd1 <= ram1.exists(k) ? ram1[k] : seed(1, k);
  end

  // reference model
  logic [31:0] m_a, m_b, m_ctrl;
  int m_col, m_row, cap_cnt;
  logic [1:0]  e_we, e_re;
  logic [19:0] e_addr;
  logic [63:0] e_wdata, cap_loc;
  logic [3:0]  e_mask;
  logic [63:0] mm0 [int];
  logic [63:0] mm1 [int];

  function automatic logic [63:0] mget(int b, int k);
    if (b == 0) return mm0.exists(k) ? mm0[k] : seed(0, k);
    return mm1.exists(k) ? mm1[k] : seed(1, k);
  endfunction

  task automatic m_step();
    m_col++;
    if (m_col == 512) begin m_col = 0; m_row = (m_row + 1) % 2048; end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_a = 0; m_b = 0; m_ctrl = 0; m_col = 0; m_row = 0; cap_cnt = 0;
      e_we = 0; e_re = 0; e_addr = 0; e_wdata = 0; e_mask = 0;
    end else begin
      int k, bk;
      logic [63:0] loc;
      logic do_cap;
      do_cap = (cap_cnt == 1);
      if (cap_cnt > 0) cap_cnt--;
      e_we = 0; e_re = 0;
      if (host_we) begin
        case (host_sel)
          2'd0: m_a = host_wdata;
          2'd1: begin
            m_b = host_wdata;
            if (m_ctrl[0]) begin
              k = m_row * 512 + m_col;
              loc = {m_b[31:16], m_a[31:16], m_b[15:0], m_a[15:0]};
              e_we = {m_ctrl[30], m_ctrl[31]};
              e_addr = 20'(k); e_wdata = loc; e_mask = m_ctrl[23:20];
              if (m_ctrl[31]) mm0[k] = merge(mget(0, k), loc, e_mask);
              if (m_ctrl[30]) mm1[k] = merge(mget(1, k), loc, e_mask);
              if (m_ctrl[17]) m_step();
            end
          end
          2'd2: begin
            m_col = int'(host_wdata[8:0]);
            m_row = int'(host_wdata[22:12]);
            if (m_ctrl[0] && m_ctrl[16]) begin
              bk = (m_ctrl[30] && !m_ctrl[31]) ? 1 : 0;
              k = m_row * 512 + m_col;
              e_re = (bk == 1) ? 2'b10 : 2'b01;
              e_addr = 20'(k);
              cap_loc = mget(bk, k);
              cap_cnt = 2;
              if (m_ctrl[17]) m_step();
            end
          end
          default: m_ctrl = host_wdata;
        endcase
      end
      if (do_cap) begin m_a = half_a(cap_loc); m_b = half_b(cap_loc); end
    end
  end

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] m_rdata(logic [1:0] s);
    case (s)
      2'd0: return m_a;
      2'd1: return m_b;
      2'd2: return {9'd0, 11'(m_row), 3'd0, 9'(m_col)};
      default: return m_ctrl;
    endcase
  endfunction

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R4 write strobe", 64'(mem_we), 64'(e_we));
      chk("R8 read strobe", 64'(mem_re), 64'(e_re));
      if (e_we != 0) begin
        chk("R4 write address", 64'(mem_addr), 64'(e_addr));
        chk("R5 write word", mem_wdata, e_wdata);
        chk("R5 lane mask", 64'(mem_wmask), 64'(e_mask));
      end
      if (e_re != 0) chk("R7 read address", 64'(mem_addr), 64'(e_addr));
      chk("R2 register readback", 64'(host_rdata), 64'(m_rdata(host_sel)));
    end
  end

  task automatic wr(logic [1:0] s, logic [31:0] d);
    @(posedge clk); #1;
    host_we = 1'b1; host_sel = s; host_wdata = d;
    @(posedge clk); #1;
    host_we = 1'b0;
  endtask

  task automatic expect_reg(logic [1:0] s, logic [31:0] exp, string tag);
    @(posedge clk); #1;
    host_we = 1'b0; host_sel = s;
    #2;
    chk(tag, 64'(host_rdata), 64'(exp));
  endtask

  task automatic do_read(logic [31:0] ctrl, logic [31:0] addr);
    wr(2'd3, ctrl);
    wr(2'd2, addr);
    repeat (4) @(posedge clk);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    logic [63:0] s;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    expect_reg(2'd0, 32'h0, "R1 data A reset");
    expect_reg(2'd1, 32'h0, "R1 data B reset");
    expect_reg(2'd2, 32'h0, "R1 address reset");
    expect_reg(2'd3, 32'h0, "R1 control reset");
    chk("R1 no strobes", 64'({mem_we, mem_re}), 64'h0);
    // R2 address layout
    wr(2'd2, 32'hFFFF_FFFF);
    expect_reg(2'd2, 32'h007F_F1FF, "R2 address field layout");
    // R4 full commit to bank 0, no step
    wr(2'd3, 32'h80F0_0001);
    wr(2'd2, 32'h0000_300A);
    wr(2'd0, 32'h7FFF_0421);
    wr(2'd1, 32'h7FFF_0842);
    expect_reg(2'd2, 32'h0000_300A, "R6 no step with bit 17 clear");
    do_read(32'h0001_0001, 32'h0000_300A);
    expect_reg(2'd0, 32'h7FFF_0421, "R7 read back data A");
    expect_reg(2'd1, 32'h7FFF_0842, "R7 read back data B");
    // R5 partial lanes: pixel 0 and depth 0 only
    wr(2'd3, 32'h8050_0001);
    wr(2'd0, 32'h1111_2222);
    wr(2'd1, 32'h3333_4444);
    do_read(32'h0001_0001, 32'h0000_300A);
    expect_reg(2'd0, 32'h1111_2222, "R5 masked lanes written");
    expect_reg(2'd1, 32'h7FFF_0842, "R5 unmasked lanes kept");
    // R3 staging data A only leaves RAM unchanged
    wr(2'd3, 32'h80F0_0001);
    wr(2'd2, 32'h0000_200C);
    wr(2'd0, 32'hDEAD_BEEF);
    do_read(32'h0001_0001, 32'h0000_200C);
    s = seed(0, 2 * 512 + 12);
    expect_reg(2'd0, half_a(s), "R3 data A alone does not write");
    // R8 bank selection
    wr(2'd3, 32'h40F0_0001);
    wr(2'd2, 32'h0000_5007);
    wr(2'd0, 32'hAAAA_5555);
    wr(2'd1, 32'hBBBB_6666);
    do_read(32'h4001_0001, 32'h0000_5007);
    expect_reg(2'd0, 32'hAAAA_5555, "R8 bank 1 read A");
    expect_reg(2'd1, 32'hBBBB_6666, "R8 bank 1 read B");
    do_read(32'hC001_0001, 32'h0000_5007);
    s = seed(0, 5 * 512 + 7);
    expect_reg(2'd1, half_b(s), "R8 both bank bits read bank 0");
    // R6 step with carry and wrap
    wr(2'd3, 32'h80F2_0001);
    wr(2'd2, 32'h0000_71FE);
    wr(2'd0, 32'h7FFF_0001);
    wr(2'd1, 32'h7FFF_0002);
    expect_reg(2'd2, 32'h0000_71FF, "R6 column step");
    wr(2'd1, 32'h7FFF_0003);
    expect_reg(2'd2, 32'h0000_8000, "R6 carry into row");
    wr(2'd2, 32'h007F_F1FF);
    wr(2'd1, 32'h7FFF_0004);
    expect_reg(2'd2, 32'h0000_0000, "R6 wrap to origin");
    // R10 read with step
    do_read(32'h0003_0001, 32'h0000_300A);
    expect_reg(2'd2, 32'h0000_300B, "R10 address stepped after read");
    expect_reg(2'd0, 32'h1111_2222, "R10 read used loaded address");
    // R9 disabled access
    wr(2'd3, 32'h80F3_0000);
    wr(2'd2, 32'h0000_1001);
    expect_reg(2'd2, 32'h0000_1001, "R9 no step on address write");
    wr(2'd1, 32'h1234_5678);
    expect_reg(2'd2, 32'h0000_1001, "R9 no step on data write");
    expect_reg(2'd1, 32'h1234_5678, "R9 data still staged");
    do_read(32'h0001_0001, 32'h0000_1001);
    s = seed(0, 1 * 512 + 1);
    expect_reg(2'd1, half_b(s), "R9 RAM untouched while disabled");
    repeat (3) @(posedge clk);
    finish_up();
  end
endmodule